// File: doc/BRIEF.md
# Scalar Single-Cycle Integer ALU

This execution unit serves a small 32-bit load/store core. An opcode, a register operand `opA`, and a second operand go in each cycle. The second operand is either the register value `opB` or an 8-bit immediate, zero-extended to 32 bits. The unit returns the combinational result and a branch-taken decision in the same cycle.

The unit handles several kinds of operation:
- plain and carry-chained add and subtract, in both directions;
- bitwise logic;
- logical shifts;
- unsigned minimum and maximum;
- single-bit set and clear;
- a scan for the highest bit of a chosen value;
- compare and bit-test branch conditions.

A carry flag register lives inside the unit. Only the six add/subtract opcodes update it, and only on a clock edge where `opValid` is high. The carry-using opcodes read the flag value present before that edge, so chained arithmetic works on back-to-back cycles.

Top module: `scalar_alu`

## Requirements
- R1: Opcode 0 returns a+b and opcode 1 returns a+b+carry, where b is the effective second operand. On the next edge with `opValid` high, the carry flag takes bit 32 of the full 33-bit sum.
- R2: The subtract opcodes each take bit 32 of the 33-bit difference into the carry flag, where it serves as the borrow:
  - opcode 2 returns a-b;
  - opcode 3 returns a-b-carry;
  - opcode 4 returns b-a;
  - opcode 5 returns b-a-carry.
- R3: Reset clears the carry flag to 0. The flag keeps its value on any edge where the opcode is not in the range 0..5 or `opValid` is low.
- R4: The logic opcodes are 6 AND, 7 OR, 8 XOR and 9 NOT. Opcode 9 returns the complement of a and does not depend on b.
- R5: Opcode 10 shifts a left and opcode 11 shifts a right, both with zero fill, by b[4:0]. Higher bits of b are ignored.
- R6: Opcode 12 returns a when b > a and b otherwise. Opcode 13 returns b when b > a and a otherwise. Both comparisons are unsigned.
- R7: Opcode 14 sets, and opcode 15 clears, bit b[4:0] of a. All other bits pass through unchanged.
- R8: Opcode 16 scans a from bit 31 down to bit 0 for the first bit equal to b[0] and returns that bit's index. It returns 32 when no bit matches.
- R9: `branchTaken` is taken under these compare-branch conditions, with b as the left-hand term:
  - opcode 17: b > a;
  - opcode 18: b >= a;
  - opcode 19: b < a;
  - opcode 20: b <= a;
  - opcode 21: b == a;
  - opcode 22: b != a.
- R10: Opcode 23 is taken when bit b[4:0] of a is 1. Opcode 24 is taken when that bit is 0.
- R11: When `useImm` is 1, the effective second operand is `immVal` zero-extended to 32 bits and `opB` is ignored.
- R12: `branchTaken` is 0 for every opcode outside 17..24. Opcodes 17..31 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the carry flag |
| opValid | input | 1 | Operation is issued; enables the carry update |
| opCode | input | 5 | Operation code (see requirements) |
| opA | input | 32 | Register operand a |
| opB | input | 32 | Register second operand |
| useImm | input | 1 | Select the immediate as second operand |
| immVal | input | 8 | Immediate value, zero-extended |
| result | output | 32 | Combinational result |
| carryFlag | output | 1 | Stored carry/borrow flag |
| branchTaken | output | 1 | Branch condition met |

## Verification
Two things can meet in one cycle: the write of the carry flag by an arithmetic op, and the read of that same flag by the carry-using op issued right behind it. The bench provokes this by issuing an add that overflows and, on the very next cycle, an add-with-carry of zeros. The second op must return 1. A borrow-producing subtract followed directly by a reverse subtract-with-borrow checks the same hand-off on the subtract path.

// File: rtl/scalar_alu_pkg.sv
package scalar_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SUC  = 5'd3,
    OP_RSB  = 5'd4,  OP_RSC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_LSL  = 5'd10, OP_LSR  = 5'd11,
    OP_MIN  = 5'd12, OP_MAX  = 5'd13, OP_SET  = 5'd14, OP_CLR  = 5'd15,
    OP_LMBD = 5'd16, OP_BGT  = 5'd17, OP_BGE  = 5'd18, OP_BLT  = 5'd19,
    OP_BLE  = 5'd20, OP_BEQ  = 5'd21, OP_BNE  = 5'd22, OP_BBS  = 5'd23,
    OP_BBC  = 5'd24
  } opcode_e;

  typedef enum logic [2:0] {
    OUT_ZERO, OUT_ARITH, OUT_LOGIC, OUT_SHIFT, OUT_MINMAX, OUT_BIT, OUT_SCAN
  } outsel_e;

  typedef enum logic [3:0] {
    BR_NONE, BR_GT, BR_GE, BR_LT, BR_LE, BR_EQ, BR_NE, BR_BS, BR_BC
  } brsel_e;

  typedef enum logic [1:0] {
    LG_AND, LG_OR, LG_XOR, LG_NOT
  } logicop_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic     arith;      // op writes the carry flag
    logic     doSub;      // subtract instead of add
    logic     swap;       // reverse operand order
    logic     useCarry;   // fold the stored carry in
    outsel_e  outSel;
    logicop_e logicOp;
    logic     shiftRight;
    logic     pickMax;
    logic     bitSet;
    brsel_e   brSel;
  } ctrl_t;

endpackage

// File: rtl/scalar_alu_ctrl.sv
module scalar_alu_ctrl
  import scalar_alu_pkg::*;
(
  input  logic [4:0] opCode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.outSel     = OUT_ZERO;
    ctrl.logicOp    = LG_AND;
    ctrl.brSel      = BR_NONE;
    case (opCode)
      OP_ADD:  begin ctrl.arith = 1'b1; ctrl.outSel = OUT_ARITH; end
      OP_ADC:  begin ctrl.arith = 1'b1; ctrl.useCarry = 1'b1; ctrl.outSel = OUT_ARITH; end
      OP_SUB:  begin ctrl.arith = 1'b1; ctrl.doSub = 1'b1; ctrl.outSel = OUT_ARITH; end
      OP_SUC:  begin ctrl.arith = 1'b1; ctrl.doSub = 1'b1; ctrl.useCarry = 1'b1;
                     ctrl.outSel = OUT_ARITH; end
      OP_RSB:  begin ctrl.arith = 1'b1; ctrl.doSub = 1'b1; ctrl.swap = 1'b1;
                     ctrl.outSel = OUT_ARITH; end
      OP_RSC:  begin ctrl.arith = 1'b1; ctrl.doSub = 1'b1; ctrl.swap = 1'b1;
                     ctrl.useCarry = 1'b1; ctrl.outSel = OUT_ARITH; end
      OP_AND:  begin ctrl.outSel = OUT_LOGIC; ctrl.logicOp = LG_AND; end
      OP_OR:   begin ctrl.outSel = OUT_LOGIC; ctrl.logicOp = LG_OR;  end
      OP_XOR:  begin ctrl.outSel = OUT_LOGIC; ctrl.logicOp = LG_XOR; end
      OP_NOT:  begin ctrl.outSel = OUT_LOGIC; ctrl.logicOp = LG_NOT; end
      OP_LSL:  ctrl.outSel = OUT_SHIFT;
      OP_LSR:  begin ctrl.outSel = OUT_SHIFT; ctrl.shiftRight = 1'b1; end
      OP_MIN:  ctrl.outSel = OUT_MINMAX;
      OP_MAX:  begin ctrl.outSel = OUT_MINMAX; ctrl.pickMax = 1'b1; end
      OP_SET:  begin ctrl.outSel = OUT_BIT; ctrl.bitSet = 1'b1; end
      OP_CLR:  ctrl.outSel = OUT_BIT;
      OP_LMBD: ctrl.outSel = OUT_SCAN;
      OP_BGT:  ctrl.brSel = BR_GT;
      OP_BGE:  ctrl.brSel = BR_GE;
      OP_BLT:  ctrl.brSel = BR_LT;
      OP_BLE:  ctrl.brSel = BR_LE;
      OP_BEQ:  ctrl.brSel = BR_EQ;
      OP_BNE:  ctrl.brSel = BR_NE;
      OP_BBS:  ctrl.brSel = BR_BS;
      OP_BBC:  ctrl.brSel = BR_BC;
      default: ;
    endcase
  end

endmodule

// File: rtl/scalar_alu_dp.sv
module scalar_alu_dp
  import scalar_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opBEff,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryNext,
  output logic              branchTaken
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int IDX_W   = $clog2(DATA_W) + 1;

  logic [SHAMT_W-1:0] shAmt;
  logic [DATA_W-1:0]  lhs, rhs, logicRes, shiftRes, minMaxRes, bitRes, bitMask;
  logic [DATA_W:0]    cinExt, arithRes;
  logic [DATA_W-1:0]  matchVec;
  logic [IDX_W-1:0]   scanIdx;
  logic               bGtA, bEqA;

  assign shAmt = opBEff[SHAMT_W-1:0];

  // Adder / subtractor with one extra bit for carry or borrow
  assign lhs    = ctrl.swap ? opBEff : opA;
  assign rhs    = ctrl.swap ? opA : opBEff;
  assign cinExt = {{DATA_W{1'b0}}, carryIn & ctrl.useCarry};

  always_comb begin
    if (ctrl.doSub) arithRes = {1'b0, lhs} - {1'b0, rhs} - cinExt;
    else            arithRes = {1'b0, lhs} + {1'b0, rhs} + cinExt;
  end
  assign carryNext = arithRes[DATA_W];

  always_comb begin
    case (ctrl.logicOp)
      LG_AND:  logicRes = opA & opBEff;
      LG_OR:   logicRes = opA | opBEff;
      LG_XOR:  logicRes = opA ^ opBEff;
      default: logicRes = ~opA;
    endcase
  end

  assign shiftRes  = ctrl.shiftRight ? (opA >> shAmt) : (opA << shAmt);

  assign bGtA      = opBEff > opA;
  assign bEqA      = opBEff == opA;
  assign minMaxRes = (bGtA ^ ctrl.pickMax) ? opA : opBEff;

  assign bitMask   = {{(DATA_W-1){1'b0}}, 1'b1} << shAmt;
  assign bitRes    = ctrl.bitSet ? (opA | bitMask) : (opA & ~bitMask);

  // Per-bit match against the wanted value, then highest-index priority
  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    assign matchVec[i] = ~(opA[i] ^ opBEff[0]);
  end

  always_comb begin
    scanIdx = IDX_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (matchVec[i]) scanIdx = IDX_W'(i);
    end
  end

  always_comb begin
    case (ctrl.outSel)
      OUT_ARITH:  result = arithRes[DATA_W-1:0];
      OUT_LOGIC:  result = logicRes;
      OUT_SHIFT:  result = shiftRes;
      OUT_MINMAX: result = minMaxRes;
      OUT_BIT:    result = bitRes;
      OUT_SCAN:   result = DATA_W'(scanIdx);
      default:    result = '0;
    endcase
  end

  always_comb begin
    case (ctrl.brSel)
      BR_GT:   branchTaken = bGtA;
      BR_GE:   branchTaken = bGtA | bEqA;
      BR_LT:   branchTaken = ~(bGtA | bEqA);
      BR_LE:   branchTaken = ~bGtA;
      BR_EQ:   branchTaken = bEqA;
      BR_NE:   branchTaken = ~bEqA;
      BR_BS:   branchTaken = opA[shAmt];
      BR_BC:   branchTaken = ~opA[shAmt];
      default: branchTaken = 1'b0;
    endcase
  end

endmodule

// File: rtl/scalar_alu.sv
module scalar_alu
  import scalar_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [4:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              carryFlag,
  output logic              branchTaken
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] opBEff;
  logic              carryNext;
  logic              carryQ;

  assign opBEff = useImm ? {{(DATA_W-IMM_W){1'b0}}, immVal} : opB;

  scalar_alu_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  scalar_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .ctrl        (ctrl),
    .opA         (opA),
    .opBEff      (opBEff),
    .carryIn     (carryQ),
    .result      (result),
    .carryNext   (carryNext),
    .branchTaken (branchTaken)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                    carryQ <= 1'b0;
    else if (opValid && ctrl.arith) carryQ <= carryNext;
  end

  assign carryFlag = carryQ;

endmodule

// File: rtl/scalar_alu_chk.sv
module scalar_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [4:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opBEff,
  input logic [DATA_W-1:0] result,
  input logic              carryFlag,
  input logic              branchTaken
);

  logic [DATA_W:0] plainSum;
  assign plainSum = {1'b0, opA} + {1'b0, opBEff};

  // R3
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && opCode <= 5'd5) |=> $stable(carryFlag));

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 5'd0) |-> result == plainSum[DATA_W-1:0]);

  // R1
  add_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd0) |=> carryFlag == $past(plainSum[DATA_W]));

  // R4
  not_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 5'd9) |-> result == ~opA);

  // R12
  branch_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (opCode >= 5'd17 && opCode <= 5'd24));

  // R9
  beq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 5'd21) |-> branchTaken == (opA == opBEff));

endmodule

bind scalar_alu scalar_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opValid     (opValid),
  .opCode      (opCode),
  .opA         (opA),
  .opBEff      (opBEff),
  .result      (result),
  .carryFlag   (carryFlag),
  .branchTaken (branchTaken)
);

// File: tb/scalar_alu_tb.sv
`timescale 1ns/1ps
module scalar_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        useImm = 1'b0;
  logic [7:0]  immVal = '0;
  logic [31:0] result;
  logic        carryFlag, branchTaken;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] gotRes;
  logic        gotBr, gotCarry;

  always #2.5 clk = ~clk;

  scalar_alu u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .useImm(useImm), .immVal(immVal),
    .result(result), .carryFlag(carryFlag), .branchTaken(branchTaken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one op; sample combinational outputs, then the carry after the edge
  task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic vld = 1'b1, input logic ui = 1'b0, input logic [7:0] im = 8'h0);
    @(negedge clk);
    opCode = op; opA = a; opB = b; opValid = vld; useImm = ui; immVal = im;
    #1;
    gotRes = result; gotBr = branchTaken;
    @(posedge clk);
    #1;
    gotCarry = carryFlag;
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0; opCode = 5'd31;
  endtask

  task automatic t_reset();
    chk("R3 reset carry", {31'b0, carryFlag}, 32'd0);
  endtask

  task automatic t_add();
    run(5'd0, 32'hFFFF_FFFF, 32'd1);
    chk("R1 add wrap", gotRes, 32'd0);
    chk("R1 add carry", {31'b0, gotCarry}, 32'd1);
    run(5'd1, 32'd0, 32'd0);        // back-to-back: consumes carry just written
    chk("R1 adc uses fresh carry", gotRes, 32'd1);
    chk("R1 adc carry clear", {31'b0, gotCarry}, 32'd0);
    run(5'd1, 32'd5, 32'd6);
    chk("R1 adc no carry", gotRes, 32'd11);
  endtask

  task automatic t_sub();
    run(5'd2, 32'd3, 32'd5);
    chk("R2 sub", gotRes, 32'hFFFF_FFFE);
    chk("R2 sub borrow", {31'b0, gotCarry}, 32'd1);
    run(5'd3, 32'd10, 32'd3);
    chk("R2 suc", gotRes, 32'd6);
    chk("R2 suc borrow clear", {31'b0, gotCarry}, 32'd0);
    run(5'd4, 32'd3, 32'd10);
    chk("R2 rsb", gotRes, 32'd7);
    run(5'd2, 32'd1, 32'd2);
    run(5'd5, 32'd5, 32'd5);
    chk("R2 rsc", gotRes, 32'hFFFF_FFFF);
    chk("R2 rsc borrow", {31'b0, gotCarry}, 32'd1);
  endtask

  task automatic t_carry_hold();
    // carry is 1 here
    run(5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R3 carry held on logic op", {31'b0, gotCarry}, 32'd1);
    run(5'd0, 32'd1, 32'd1, 1'b0);
    chk("R3 carry held when not valid", {31'b0, gotCarry}, 32'd1);
    run(5'd30, 32'd1, 32'd1);
    chk("R3 carry held on unused code", {31'b0, gotCarry}, 32'd1);
    chk("R12 unused code result", gotRes, 32'd0);
    chk("R12 unused code no branch", {31'b0, gotBr}, 32'd0);
  endtask

  task automatic t_logic();
    run(5'd6, 32'h0000_F0F0, 32'h0000_FF00); chk("R4 and", gotRes, 32'h0000_F000);
    run(5'd7, 32'h0000_F0F0, 32'h0000_FF00); chk("R4 or",  gotRes, 32'h0000_FFF0);
    run(5'd8, 32'h0000_F0F0, 32'h0000_FF00); chk("R4 xor", gotRes, 32'h0000_0FF0);
    run(5'd9, 32'h0F0F_0F0F, 32'h1234_5678); chk("R4 not", gotRes, 32'hF0F0_F0F0);
    run(5'd9, 32'h0F0F_0F0F, 32'hFFFF_FFFF); chk("R4 not ignores b", gotRes, 32'hF0F0_F0F0);
  endtask

  task automatic t_shift();
    run(5'd10, 32'd1, 32'd33);          chk("R5 lsl masked", gotRes, 32'd2);
    run(5'd11, 32'h8000_0000, 32'd31);  chk("R5 lsr", gotRes, 32'd1);
    run(5'd11, 32'h8000_0000, 32'd32);  chk("R5 lsr by 32 masks to 0", gotRes, 32'h8000_0000);
  endtask

  task automatic t_minmax();
    run(5'd12, 32'd5, 32'hFFFF_FFFF); chk("R6 min unsigned", gotRes, 32'd5);
    run(5'd13, 32'd5, 32'hFFFF_FFFF); chk("R6 max unsigned", gotRes, 32'hFFFF_FFFF);
    run(5'd12, 32'd9, 32'd4);         chk("R6 min b", gotRes, 32'd4);
  endtask

  task automatic t_bits();
    run(5'd14, 32'd0, 32'd37);          chk("R7 set masked", gotRes, 32'h0000_0020);
    run(5'd15, 32'hFFFF_FFFF, 32'd0);   chk("R7 clr", gotRes, 32'hFFFF_FFFE);
  endtask

  task automatic t_scan();
    run(5'd16, 32'h0001_0000, 32'd1);  chk("R8 lmbd one", gotRes, 32'd16);
    run(5'd16, 32'hFFFF_FFFF, 32'd0);  chk("R8 lmbd none", gotRes, 32'd32);
    run(5'd16, 32'hFFFF_FFFE, 32'd2);  chk("R8 lmbd zero at bit0", gotRes, 32'd0);
  endtask

  task automatic t_branch();
    run(5'd17, 32'd5, 32'd6); chk("R9 gt taken", {31'b0, gotBr}, 32'd1);
    chk("R12 branch result zero", gotRes, 32'd0);
    run(5'd17, 32'd6, 32'd5); chk("R9 gt not taken", {31'b0, gotBr}, 32'd0);
    run(5'd18, 32'd7, 32'd7); chk("R9 ge equal", {31'b0, gotBr}, 32'd1);
    run(5'd19, 32'd6, 32'd5); chk("R9 lt", {31'b0, gotBr}, 32'd1);
    run(5'd20, 32'd7, 32'd7); chk("R9 le equal", {31'b0, gotBr}, 32'd1);
    run(5'd21, 32'd7, 32'd8); chk("R9 eq not taken", {31'b0, gotBr}, 32'd0);
    run(5'd22, 32'd7, 32'd8); chk("R9 ne", {31'b0, gotBr}, 32'd1);
    run(5'd23, 32'h100, 32'd40); chk("R10 bit set", {31'b0, gotBr}, 32'd1);
    run(5'd24, 32'h100, 32'd40); chk("R10 bit clear", {31'b0, gotBr}, 32'd0);
    run(5'd0, 32'd5, 32'd6);  chk("R12 add no branch", {31'b0, gotBr}, 32'd0);
  endtask

  task automatic t_imm();
    run(5'd0, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, 8'h80);
    chk("R11 imm zero-extended", gotRes, 32'h0000_0080);
    run(5'd21, 32'hFF, 32'd0, 1'b1, 1'b1, 8'hFF);
    chk("R11 imm ignores opB", {31'b0, gotBr}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_carry_hold();
    t_logic();
    t_shift();
    t_minmax();
    t_bits();
    t_scan();
    t_branch();
    t_imm();
    idle();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule